// File: doc/BRIEF.md
# Serial Path-Overhead Byte Capture Port

This block collects path-overhead bytes for an outgoing STS-3c payload envelope from an external serial source. It generates a port clock, an enable strobe and a frame strobe, and drives them toward that source. The source watches the two strobes. When it sees enable high, it launches the next overhead byte on the following falling port-clock edges, most significant bit first. The block samples each bit on the rising edge that follows. Frame high together with enable marks the J1 slot, which restarts the byte-slot count at zero.

Each completed byte leaves on a small output stream as a one-cycle valid pulse, with the byte and its slot index. The stream has no ready signal. A serial source cannot be paused partway through an overhead slot, so nothing upstream could absorb back-pressure, and the consumer must take every pulse. The C2 byte, in slot `C2_SLOT`, can come from software instead. A plain select input, standing in for bit 2 of the path control byte, picks between the serial byte and a software value `sw_c2`. Every other slot always carries the serial byte.

The slot schedule runs freely from reset. Each slot takes one strobe period and then eight data periods. After `NUM_SLOTS` slots come `GAP_PERIODS` periods with no strobe, and then the next J1 strobe.

Top module: `poh_serial_insert`

## Requirements
- R1: While synchronous active-high `rst` is high, `poh_clk_o` is 0, `poh_en_o` and `poh_frm_o` are 1, and `ins_valid` is 0. The first byte completed after reset carries slot index 0.
- R2: `poh_clk_o` toggles once every `CLK_DIV` clock cycles, so one port period is 2*`CLK_DIV` cycles.
- R3: `poh_en_o` is high for exactly one port period before each byte and low during its eight data periods. `poh_frm_o` is high only together with `poh_en_o`, and only in the period before slot 0. Both strobes change only on falling port-clock edges.
- R4: The bit on `poh_sdi` at the first rising port-clock edge after a strobe period is bit 7 of the byte. The next seven rising edges carry bits 6 down to 0.
- R5: `ins_valid` is high for exactly one clock cycle. It rises in the cycle that begins at the rising port-clock edge that samples bit 0.
- R6: `ins_slot` is 0 for the byte that follows a frame strobe, and it increments by one for each later byte, up to `NUM_SLOTS`-1.
- R7: After the byte in slot `NUM_SLOTS`-1, exactly `GAP_PERIODS` port periods pass with both strobes low, not counting that byte's last data period. The next strobe period has the frame strobe high.
- R8: In slot `C2_SLOT` with `c2_serial_sel` = 0, `ins_byte` equals `sw_c2`, and the serial bits of that slot have no effect.
- R9: In slot `C2_SLOT` with `c2_serial_sel` = 1, `ins_byte` is the byte taken from the serial port.
- R10: In every slot other than `C2_SLOT`, `ins_byte` is the serially captured byte, whatever `c2_serial_sel` and `sw_c2` hold. `poh_sdi` during strobe and gap periods has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| c2_serial_sel | input | 1 | C2 source: 0 software value, 1 serial port |
| sw_c2 | input | 8 | Software-programmed C2 byte |
| poh_sdi | input | 1 | Serial overhead data from the external source |
| poh_clk_o | output | 1 | Port clock toward the external source |
| poh_en_o | output | 1 | Enable strobe: the next byte slot starts |
| poh_frm_o | output | 1 | Frame strobe: the next byte is J1 |
| ins_valid | output | 1 | One-cycle pulse: a completed byte is present |
| ins_byte | output | 8 | Completed overhead byte |
| ins_slot | output | $clog2(NUM_SLOTS) | Slot index of the byte, J1 = 0 |

## Verification
A bit counter that drifts by one shows at the ports within the same slot. The valid pulse moves by a whole port period away from its expected clock, and the byte appears shifted by one bit position. A wrong slot or gap counter shows at the next strobe period, as a frame strobe in the wrong place or a gap that is too short or too long. A C2 selection error shows only in that slot's byte. For that reason the bench sweeps the select and the software value over many frames, with data patterns that differ from the software value.

// File: rtl/poh_pkg.sv
package poh_pkg;
  typedef logic [7:0] poh_byte_t;

  typedef enum logic [1:0] {
    SEG_STROBE = 2'd0,
    SEG_DATA   = 2'd1,
    SEG_GAP    = 2'd2
  } seg_e;

  localparam int unsigned BITS_PER_BYTE = 8;
endpackage

// File: rtl/poh_clkgen.sv
module poh_clkgen #(
  parameter int CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  output logic pclk,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] div_cnt;
  logic          wrap;

  assign wrap     = (div_cnt == CNT_LAST);
  assign rise_evt = wrap && !pclk;
  assign fall_evt = wrap && pclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      pclk    <= 1'b0;
    end else if (wrap) begin
      div_cnt <= '0;
      pclk    <= ~pclk;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/poh_slot_seq.sv
module poh_slot_seq
  import poh_pkg::*;
#(
  parameter int NUM_SLOTS   = 9,
  parameter int GAP_PERIODS = 4,
  parameter int SLOT_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_evt,
  input  logic              fall_evt,
  output logic              en_strobe,
  output logic              frm_strobe,
  output logic              sample_now,
  output logic              byte_done,
  output logic [SLOT_W-1:0] slot_idx
);
  localparam int GW = (GAP_PERIODS > 1) ? $clog2(GAP_PERIODS) : 1;
  localparam bit HAS_GAP = (GAP_PERIODS > 0);
  localparam logic [GW-1:0] GAP_LAST = GW'((GAP_PERIODS > 0) ? GAP_PERIODS - 1 : 0);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);
  localparam logic [2:0] BIT_LAST = 3'(BITS_PER_BYTE - 1);

  seg_e              seg_q, seg_d;
  logic [2:0]        bit_q, bit_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [GW-1:0]     gap_q, gap_d;

  always_comb begin
    seg_d  = seg_q;
    bit_d  = bit_q;
    slot_d = slot_q;
    gap_d  = gap_q;
    if (fall_evt) begin
      case (seg_q)
        SEG_STROBE: begin
          seg_d = SEG_DATA;
          bit_d = '0;
        end
        SEG_DATA: begin
          if (bit_q == BIT_LAST) begin
            if (slot_q == SLOT_LAST) begin
              if (HAS_GAP) begin
                seg_d = SEG_GAP;
                gap_d = '0;
              end else begin
                seg_d  = SEG_STROBE;
                slot_d = '0;
              end
            end else begin
              seg_d  = SEG_STROBE;
              slot_d = slot_q + 1'b1;
            end
          end else begin
            bit_d = bit_q + 1'b1;
          end
        end
        SEG_GAP: begin
          if (gap_q == GAP_LAST) begin
            seg_d  = SEG_STROBE;
            slot_d = '0;
          end else begin
            gap_d = gap_q + 1'b1;
          end
        end
        default: begin
          seg_d  = SEG_STROBE;
          slot_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q  <= SEG_STROBE;
      bit_q  <= '0;
      slot_q <= '0;
      gap_q  <= '0;
    end else begin
      seg_q  <= seg_d;
      bit_q  <= bit_d;
      slot_q <= slot_d;
      gap_q  <= gap_d;
    end
  end

  assign en_strobe  = (seg_q == SEG_STROBE);
  assign frm_strobe = en_strobe && (slot_q == '0);
  assign sample_now = rise_evt && (seg_q == SEG_DATA);
  assign byte_done  = sample_now && (bit_q == BIT_LAST);
  assign slot_idx   = slot_q;
endmodule

// File: rtl/poh_shift.sv
module poh_shift
  import poh_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sample_now,
  input  logic      sdi,
  output poh_byte_t cap_byte
);
  logic [6:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
    end else if (sample_now) begin
      shreg <= {shreg[5:0], sdi};
    end
  end

  assign cap_byte = {shreg, sdi};
endmodule

// File: rtl/poh_src_sel.sv
module poh_src_sel
  import poh_pkg::*;
#(
  parameter int NUM_SLOTS = 9,
  parameter int C2_SLOT   = 2,
  parameter int SLOT_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_done,
  input  logic [SLOT_W-1:0] slot_idx,
  input  poh_byte_t         cap_byte,
  input  logic              c2_serial_sel,
  input  poh_byte_t         sw_c2,
  output logic              out_valid,
  output poh_byte_t         out_byte,
  output logic [SLOT_W-1:0] out_slot
);
  poh_byte_t pick;

  generate
    if (C2_SLOT < NUM_SLOTS) begin : g_c2_override
      localparam logic [SLOT_W-1:0] C2_IDX = SLOT_W'(C2_SLOT);
      always_comb begin
        if ((slot_idx == C2_IDX) && !c2_serial_sel) pick = sw_c2;
        else pick = cap_byte;
      end
    end else begin : g_no_override
      always_comb pick = cap_byte;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
      out_slot  <= '0;
    end else begin
      out_valid <= byte_done;
      if (byte_done) begin
        out_byte <= pick;
        out_slot <= slot_idx;
      end
    end
  end
endmodule

// File: rtl/poh_serial_insert.sv
module poh_serial_insert
  import poh_pkg::*;
#(
  parameter int CLK_DIV     = 2,
  parameter int NUM_SLOTS   = 9,
  parameter int GAP_PERIODS = 4,
  parameter int C2_SLOT     = 2,
  localparam int SLOT_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              c2_serial_sel,
  input  logic [7:0]        sw_c2,
  input  logic              poh_sdi,
  output logic              poh_clk_o,
  output logic              poh_en_o,
  output logic              poh_frm_o,
  output logic              ins_valid,
  output logic [7:0]        ins_byte,
  output logic [SLOT_W-1:0] ins_slot
);
  logic              rise_evt, fall_evt;
  logic              sample_now, byte_done;
  logic [SLOT_W-1:0] slot_idx;
  poh_byte_t         cap_byte;

  poh_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
    .clk      (clk),
    .rst      (rst),
    .pclk     (poh_clk_o),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  poh_slot_seq #(
    .NUM_SLOTS   (NUM_SLOTS),
    .GAP_PERIODS (GAP_PERIODS),
    .SLOT_W      (SLOT_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .rise_evt   (rise_evt),
    .fall_evt   (fall_evt),
    .en_strobe  (poh_en_o),
    .frm_strobe (poh_frm_o),
    .sample_now (sample_now),
    .byte_done  (byte_done),
    .slot_idx   (slot_idx)
  );

  poh_shift u_shift (
    .clk        (clk),
    .rst        (rst),
    .sample_now (sample_now),
    .sdi        (poh_sdi),
    .cap_byte   (cap_byte)
  );

  poh_src_sel #(
    .NUM_SLOTS (NUM_SLOTS),
    .C2_SLOT   (C2_SLOT),
    .SLOT_W    (SLOT_W)
  ) u_sel (
    .clk           (clk),
    .rst           (rst),
    .byte_done     (byte_done),
    .slot_idx      (slot_idx),
    .cap_byte      (cap_byte),
    .c2_serial_sel (c2_serial_sel),
    .sw_c2         (sw_c2),
    .out_valid     (ins_valid),
    .out_byte      (ins_byte),
    .out_slot      (ins_slot)
  );
endmodule

// File: rtl/poh_serial_insert_chk.sv
module poh_serial_insert_chk #(
  parameter int CLK_DIV   = 2,
  parameter int NUM_SLOTS = 9,
  parameter int C2_SLOT   = 2,
  parameter int SLOT_W    = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              c2_serial_sel,
  input logic [7:0]        sw_c2,
  input logic              poh_clk_o,
  input logic              poh_en_o,
  input logic              poh_frm_o,
  input logic              ins_valid,
  input logic [7:0]        ins_byte,
  input logic [SLOT_W-1:0] ins_slot
);
  logic        pclk_prev;
  int unsigned run;

  always_ff @(posedge clk) begin
    if (rst) begin
      pclk_prev <= 1'b0;
      run       <= 0;
    end else begin
      pclk_prev <= poh_clk_o;
      run       <= (poh_clk_o != pclk_prev) ? 1 : run + 1;
    end
  end

  p_pclk_half_r2: assert property (@(posedge clk) disable iff (rst)
    (poh_clk_o != pclk_prev) |-> (run == CLK_DIV));

  p_frame_in_enable_r3: assert property (@(posedge clk) disable iff (rst)
    poh_frm_o |-> poh_en_o);

  p_strobe_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
    (poh_en_o != $past(poh_en_o)) |-> (!poh_clk_o && $past(poh_clk_o)));

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    ins_valid |=> !ins_valid);

  p_valid_on_rise_r5: assert property (@(posedge clk) disable iff (rst)
    ins_valid |-> (poh_clk_o && !$past(poh_clk_o)));

  p_slot_range_r6: assert property (@(posedge clk) disable iff (rst)
    ins_valid |-> (ins_slot < SLOT_W'(NUM_SLOTS)));

  p_c2_software_r8: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && (ins_slot == SLOT_W'(C2_SLOT)) && !$past(c2_serial_sel))
      |-> (ins_byte == $past(sw_c2)));
endmodule

bind poh_serial_insert poh_serial_insert_chk #(
  .CLK_DIV   (CLK_DIV),
  .NUM_SLOTS (NUM_SLOTS),
  .C2_SLOT   (C2_SLOT),
  .SLOT_W    (SLOT_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .c2_serial_sel (c2_serial_sel),
  .sw_c2         (sw_c2),
  .poh_clk_o     (poh_clk_o),
  .poh_en_o      (poh_en_o),
  .poh_frm_o     (poh_frm_o),
  .ins_valid     (ins_valid),
  .ins_byte      (ins_byte),
  .ins_slot      (ins_slot)
);

// File: tb/test_poh_serial_insert.sv
module test_poh_serial_insert;
  localparam int DIV  = 2;
  localparam int N    = 9;
  localparam int GAP  = 4;
  localparam int C2   = 2;
  localparam int SW   = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          c2_serial_sel = 1'b0;
  logic [7:0]    sw_c2 = 8'h00;
  logic          poh_sdi = 1'b0;
  logic          poh_clk_o, poh_en_o, poh_frm_o, ins_valid;
  logic [7:0]    ins_byte;
  logic [SW-1:0] ins_slot;

  always #10 clk = ~clk;

  poh_serial_insert #(.CLK_DIV(DIV), .NUM_SLOTS(N), .GAP_PERIODS(GAP), .C2_SLOT(C2)) i_poh_serial_insert (
    .clk(clk), .rst(rst), .c2_serial_sel(c2_serial_sel), .sw_c2(sw_c2), .poh_sdi(poh_sdi),
    .poh_clk_o(poh_clk_o), .poh_en_o(poh_en_o), .poh_frm_o(poh_frm_o),
    .ins_valid(ins_valid), .ins_byte(ins_byte), .ins_slot(ins_slot)
  );

  int  n_chk = 0, n_bad = 0;
  bit  done = 0;

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int f, int s);
    case (f % 4)
      0: return 8'(f * 29 + s * 53 + 7);
      1: return (s % 2 == 0) ? 8'hAA : 8'h55;
      2: return (s == 0) ? 8'h00 : 8'hFF;
      default: return 8'(~(s * 17 + f));
    endcase
  endfunction

  // External source model and output checker
  logic       last_p = 0, seen_en = 0, seen_frm = 0, sending = 0, first = 1;
  int         run = 0, bitpos = 0, slot_m = 0, idle_cnt = 0, frames = 0, wait_v = 0;
  int         bytes_ok = 0;
  logic [7:0] cur_byte = 0, exp_byte = 0;
  int         exp_slot = 0;

  always @(negedge clk) begin
    if (rst) begin
      last_p = 0; seen_en = 0; seen_frm = 0; sending = 0; first = 1;
      run = 0; wait_v = 0; idle_cnt = 0;
    end else begin
      // R2: port clock half period
      run++;
      if (poh_clk_o != last_p) begin
        check(run == DIV, "R2 half period", run, DIV);
        run = 0;
      end
      // R5: valid timing, R6/R4/R8/R9/R10 content
      if (wait_v > 0) begin
        wait_v--;
        if (wait_v == 0) begin
          check(ins_valid == 1'b1, "R5 valid at bit0 sample", ins_valid, 1);
          check(int'(ins_slot) == exp_slot, "R6 slot index", ins_slot, exp_slot);
          if (exp_slot == C2 && !c2_serial_sel)
            check(ins_byte == exp_byte, "R8 software C2", ins_byte, exp_byte);
          else if (exp_slot == C2)
            check(ins_byte == exp_byte, "R9 serial C2", ins_byte, exp_byte);
          else
            check(ins_byte == exp_byte, "R4/R10 serial byte", ins_byte, exp_byte);
          bytes_ok++;
        end
      end else if (ins_valid) begin
        check(0, "R5 unexpected valid", 1, 0);
      end
      // falling port edge: act as the external source
      if (last_p && !poh_clk_o) begin
        if (seen_en) begin
          if (sending) check(0, "R3 strobe during data", 1, 0);
          if (seen_frm) begin
            if (!first) begin
              check(idle_cnt == GAP + 1, "R7 gap before J1", idle_cnt, GAP + 1);
              check(slot_m == N - 1, "R7 slots per frame", slot_m, N - 1);
            end
            first = 0;
            slot_m = 0;
            frames++;
            c2_serial_sel <= (frames % 3 != 0);
            sw_c2 <= 8'(frames * 41 + 3);
          end else begin
            if (!first) check(idle_cnt == 1, "R3 single strobe period", idle_cnt, 1);
            slot_m++;
            check(slot_m < N, "R3 frame strobe missing", slot_m, N - 1);
          end
          cur_byte = pat(frames, slot_m);
          bitpos = 7;
          poh_sdi <= cur_byte[7];
          sending = 1;
          idle_cnt = 0;
        end else if (sending) begin
          bitpos--;
          poh_sdi <= cur_byte[bitpos];
          if (bitpos == 0) begin
            sending = 0;
            wait_v = DIV;
            exp_slot = slot_m;
            exp_byte = (slot_m == C2 && !c2_serial_sel) ? sw_c2 : cur_byte;
          end
        end else begin
          idle_cnt++;
          poh_sdi <= ~poh_sdi;  // junk outside data periods (R10)
        end
      end
      if (poh_clk_o) begin
        seen_en  = poh_en_o;
        seen_frm = poh_frm_o;
      end
      last_p = poh_clk_o;
    end
  end

  task automatic check_reset_state();
    check(poh_clk_o == 1'b0, "R1 port clock in reset", poh_clk_o, 0);
    check(poh_en_o == 1'b1, "R1 enable in reset", poh_en_o, 1);
    check(poh_frm_o == 1'b1, "R1 frame in reset", poh_frm_o, 1);
    check(ins_valid == 1'b0, "R1 valid in reset", ins_valid, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check_reset_state();
    rst <= 1'b0;
    while (frames < 20) @(negedge clk);
    while (!(sending && bitpos == 4)) @(negedge clk);
    rst <= 1'b1;
    repeat (3) @(negedge clk);
    check_reset_state();
    rst <= 1'b0;
    while (frames < 32) @(negedge clk);
    repeat (20) @(negedge clk);
    check(bytes_ok >= 30 * N, "R6 bytes delivered", bytes_ok, 30 * N);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", frames, 32);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule